// File: doc/BRIEF.md
# Dual-Mode Stack Pop Sequencer

This block carries out one register-pair pop from a byte-wide stack held in memory. It has two addressing modes. In long mode it reads three bytes through a 24-bit stack pointer. In compatibility mode it reads two bytes through a 16-bit stack pointer, with an 8-bit base value placed above that pointer to form the full address. A size-override code attached to the instruction can force either width, whatever the current mode bit says.

The block holds both stack pointers and the three 24-bit destination pairs (BC, DE, HL). A start strobe launches a pop and captures the mode, override and destination select. The block then drives a one-byte read port, with read data returning one cycle after each address. It raises `done` on the exact cycle that the selected instruction form requires. An override adds one leading cycle, which stands for the prefix byte, and no read is issued in that cycle. The updated register and stack pointer become visible on the cycle after `done`.

Top module: `stack_pop_seq`

## Requirements
- R1: `reg_sel` picks the destination pair: 2'b00 selects BC, 2'b01 selects DE, and 2'b10 or 2'b11 selects HL.
- R2: A long pop reads addresses `sp_long`, `sp_long`+1 and `sp_long`+2, in that order. The bytes go to destination bits 7:0, 15:8 and 23:16 in read order, and `sp_long` then grows by 3.
- R3: A short pop reads `{short_base, sp_short}` and then `{short_base, sp_short+1}`. The bytes go to bits 7:0 and then 15:8, bits 23:16 of the destination keep their old value, and `sp_short` then grows by 2.
- R4: `size_ovr` encoding: 2'b00 follows `long_mode`, 2'b01 forces a short pop, 2'b10 forces a long pop, and 2'b11 behaves like 2'b00.
- R5: Counting the cycle in which `start` is accepted as cycle 1, `done` is high for exactly one cycle. That cycle is cycle 3 for a short pop without override, cycle 4 for a long pop without override or a forced-short pop, and cycle 5 for a forced-long pop. New register and pointer values appear on the following cycle.
- R6: Memory reads are single cycle with one-cycle data latency. `mem_rd` is high only while `busy` or `start` is high. Without an override, the first address is driven in the start cycle. With an override, the first address is driven in the cycle after it.
- R7: A pop writes only the selected pair and only the stack pointer of the mode in use. No pair and no pointer changes in any other cycle.
- R8: A `start` pulse while `busy` is high has no effect. It triggers no reads, does not change the running pop, and writes nothing.
- R9: After reset, all pairs are zero, `sp_long` and `sp_short` hold their reset parameters, and `busy`, `done` and `mem_rd` are low.
- R10: The long pointer and its addresses wrap modulo 2^24. The short pointer and the low 16 address bits wrap modulo 2^16, including inside a single pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a pop (accepted when not busy) |
| long_mode | input | 1 | Current addressing mode, 1 = long |
| size_ovr | input | 2 | Per-instruction size override code |
| reg_sel | input | 2 | Destination pair select |
| short_base | input | 8 | Upper address byte for short pops |
| mem_rd | output | 1 | Read strobe for the stack memory |
| mem_addr | output | 24 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the address |
| busy | output | 1 | Pop in progress |
| done | output | 1 | Final cycle of the pop |
| reg_bc | output | 24 | BC pair |
| reg_de | output | 24 | DE pair |
| reg_hl | output | 24 | HL pair |
| sp_long | output | 24 | Long stack pointer |
| sp_short | output | 16 | Short stack pointer |

## Verification
The bench keeps the default byte widths and builds the block with a long-pointer reset value of 24'hFFFFFC and a short-pointer reset value of 16'hFFFD. With these starting points, a second pop in each mode crosses the top of its address space partway through its own reads. Wrap-around inside a pop is therefore reached after only a handful of directed pops, rather than after thousands. The short sequence also lets an early long pop seed bits 23:16 of a pair, so that a later short pop can show those bits are kept.

// File: rtl/pop_pkg.sv
`timescale 1ns/1ps
package pop_pkg;

    // Size-override code carried with each pop
    typedef enum logic [1:0] {
        OVR_NONE  = 2'b00,
        OVR_SHORT = 2'b01,
        OVR_LONG  = 2'b10,
        OVR_ALT   = 2'b11
    } ovr_e;

    // Destination pair select
    typedef enum logic [1:0] {
        SEL_BC  = 2'b00,
        SEL_DE  = 2'b01,
        SEL_HL  = 2'b10,
        SEL_HL2 = 2'b11
    } sel_e;

    localparam int NUM_PAIRS = 3;

endpackage

// File: rtl/pop_size_resolve.sv
`timescale 1ns/1ps
module pop_size_resolve
    import pop_pkg::*;
(
    input  logic       long_mode,
    input  logic [1:0] size_ovr,
    output logic       is_long,
    output logic       has_prefix
);

    always_comb begin
        case (size_ovr)
            OVR_SHORT: begin
                is_long    = 1'b0;
                has_prefix = 1'b1;
            end
            OVR_LONG: begin
                is_long    = 1'b1;
                has_prefix = 1'b1;
            end
            default: begin
                // no override, or the spare code: follow the mode bit
                is_long    = long_mode;
                has_prefix = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pop_addr_gen.sv
`timescale 1ns/1ps
module pop_addr_gen #(
    parameter int BYTE_W      = 8,
    parameter int LONG_BYTES  = 3,
    parameter int SHORT_BYTES = 2,
    parameter int OFF_W       = 3
) (
    input  logic                                   use_long,
    input  logic [OFF_W-1:0]                       offset,
    input  logic [BYTE_W*LONG_BYTES-1:0]           sp_long,
    input  logic [BYTE_W*SHORT_BYTES-1:0]          sp_short,
    input  logic [BYTE_W*(LONG_BYTES-SHORT_BYTES)-1:0] base,
    output logic [BYTE_W*LONG_BYTES-1:0]           addr
);

    localparam int ADDR_W = BYTE_W * LONG_BYTES;
    localparam int SSP_W  = BYTE_W * SHORT_BYTES;

    logic [ADDR_W-1:0] long_addr;
    logic [SSP_W-1:0]  short_low;

    // each sum wraps naturally in its own width
    assign long_addr = sp_long + ADDR_W'(offset);
    assign short_low = sp_short + SSP_W'(offset);

    assign addr = use_long ? long_addr : {base, short_low};

endmodule

// File: rtl/pop_seq_core.sv
`timescale 1ns/1ps
module pop_seq_core #(
    parameter int BYTE_W      = 8,
    parameter int LONG_BYTES  = 3,
    parameter int SHORT_BYTES = 2,
    parameter int OFF_W       = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         rs_long,
    input  logic                         rs_prefix,
    input  logic [1:0]                   sel_in,
    input  logic [BYTE_W-1:0]            mem_rdata,
    output logic                         busy,
    output logic                         done,
    output logic                         rd_en,
    output logic                         rd_long,
    output logic [OFF_W-1:0]             rd_off,
    output logic                         wr_long,
    output logic [1:0]                   wr_sel,
    output logic [BYTE_W*LONG_BYTES-1:0] wr_val
);

    localparam int REG_W = BYTE_W * LONG_BYTES;

    typedef struct packed {
        logic             busy;
        logic [OFF_W-1:0] phase;
        logic             long_m;
        logic             prefix;
        logic [1:0]       sel;
        logic [REG_W-1:0] acc;
    } seq_t;

    seq_t seq_d, seq_q;

    logic take, cur_long, cur_pre, arrive;
    int   ph, pre_n, nbytes, rd_i, dat_i;

    always_comb begin
        seq_d    = seq_q;
        take     = start && !seq_q.busy;
        cur_long = take ? rs_long   : seq_q.long_m;
        cur_pre  = take ? rs_prefix : seq_q.prefix;
        ph       = take ? 0 : int'(seq_q.phase);
        pre_n    = cur_pre ? 1 : 0;
        nbytes   = cur_long ? LONG_BYTES : SHORT_BYTES;
        rd_i     = ph - pre_n;
        dat_i    = rd_i - 1;

        rd_en   = (take || seq_q.busy) && (rd_i >= 0) && (rd_i < nbytes);
        rd_long = cur_long;
        rd_off  = rd_en ? OFF_W'(rd_i) : '0;
        arrive  = seq_q.busy && (dat_i >= 0) && (dat_i < nbytes);
        done    = seq_q.busy && (ph == pre_n + nbytes);

        if (take) begin
            seq_d.busy   = 1'b1;
            seq_d.long_m = rs_long;
            seq_d.prefix = rs_prefix;
            seq_d.sel    = sel_in;
            seq_d.acc    = '0;
        end

        for (int b = 0; b < LONG_BYTES; b++) begin
            if (arrive && dat_i == b)
                seq_d.acc[b*BYTE_W +: BYTE_W] = mem_rdata;
        end

        if (take || seq_q.busy)
            seq_d.phase = OFF_W'(ph + 1);
        if (done)
            seq_d.busy = 1'b0;

        busy    = seq_q.busy;
        wr_long = seq_q.long_m;
        wr_sel  = seq_q.sel;
        wr_val  = seq_d.acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seq_q <= '0;
        else
            seq_q <= seq_d;
    end

endmodule

// File: rtl/stack_pop_seq.sv
`timescale 1ns/1ps
module stack_pop_seq
    import pop_pkg::*;
#(
    parameter int          BYTE_W      = 8,
    parameter int          LONG_BYTES  = 3,
    parameter int          SHORT_BYTES = 2,
    parameter logic [23:0] LSP_RST     = 24'h000000,
    parameter logic [15:0] SSP_RST     = 16'h0000
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      start,
    input  logic                                      long_mode,
    input  logic [1:0]                                size_ovr,
    input  logic [1:0]                                reg_sel,
    input  logic [BYTE_W*(LONG_BYTES-SHORT_BYTES)-1:0] short_base,
    output logic                                      mem_rd,
    output logic [BYTE_W*LONG_BYTES-1:0]              mem_addr,
    input  logic [BYTE_W-1:0]                         mem_rdata,
    output logic                                      busy,
    output logic                                      done,
    output logic [BYTE_W*LONG_BYTES-1:0]              reg_bc,
    output logic [BYTE_W*LONG_BYTES-1:0]              reg_de,
    output logic [BYTE_W*LONG_BYTES-1:0]              reg_hl,
    output logic [BYTE_W*LONG_BYTES-1:0]              sp_long,
    output logic [BYTE_W*SHORT_BYTES-1:0]             sp_short
);

    localparam int REG_W = BYTE_W * LONG_BYTES;
    localparam int SSP_W = BYTE_W * SHORT_BYTES;
    localparam int OFF_W = $clog2(LONG_BYTES + 3) + 1;

    typedef struct packed {
        logic [NUM_PAIRS-1:0][REG_W-1:0] bank;
        logic [REG_W-1:0]                lsp;
        logic [SSP_W-1:0]                ssp;
    } arch_t;

    arch_t arch_d, arch_q;

    logic             rs_long, rs_prefix;
    logic             rd_long, wr_long;
    logic [OFF_W-1:0] rd_off;
    logic [1:0]       wr_sel;
    logic [REG_W-1:0] wr_val;
    int               dst;

    pop_size_resolve u_resolve (
        .long_mode  (long_mode),
        .size_ovr   (size_ovr),
        .is_long    (rs_long),
        .has_prefix (rs_prefix)
    );

    pop_seq_core #(
        .BYTE_W      (BYTE_W),
        .LONG_BYTES  (LONG_BYTES),
        .SHORT_BYTES (SHORT_BYTES),
        .OFF_W       (OFF_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rs_long   (rs_long),
        .rs_prefix (rs_prefix),
        .sel_in    (reg_sel),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .rd_en     (mem_rd),
        .rd_long   (rd_long),
        .rd_off    (rd_off),
        .wr_long   (wr_long),
        .wr_sel    (wr_sel),
        .wr_val    (wr_val)
    );

    pop_addr_gen #(
        .BYTE_W      (BYTE_W),
        .LONG_BYTES  (LONG_BYTES),
        .SHORT_BYTES (SHORT_BYTES),
        .OFF_W       (OFF_W)
    ) u_addr (
        .use_long (rd_long),
        .offset   (rd_off),
        .sp_long  (arch_q.lsp),
        .sp_short (arch_q.ssp),
        .base     (short_base),
        .addr     (mem_addr)
    );

    always_comb begin
        arch_d = arch_q;
        dst    = (wr_sel == SEL_HL2) ? int'(SEL_HL) : int'(wr_sel);
        for (int i = 0; i < NUM_PAIRS; i++) begin
            if (done && dst == i) begin
                if (wr_long)
                    arch_d.bank[i] = wr_val;
                else
                    arch_d.bank[i] = {arch_q.bank[i][REG_W-1:SSP_W], wr_val[SSP_W-1:0]};
            end
        end
        if (done && wr_long)
            arch_d.lsp = arch_q.lsp + REG_W'(LONG_BYTES);
        if (done && !wr_long)
            arch_d.ssp = arch_q.ssp + SSP_W'(SHORT_BYTES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arch_q.bank <= '0;
            arch_q.lsp  <= REG_W'(LSP_RST);
            arch_q.ssp  <= SSP_W'(SSP_RST);
        end else begin
            arch_q <= arch_d;
        end
    end

    assign reg_bc   = arch_q.bank[0];
    assign reg_de   = arch_q.bank[1];
    assign reg_hl   = arch_q.bank[2];
    assign sp_long  = arch_q.lsp;
    assign sp_short = arch_q.ssp;

endmodule

// File: rtl/pop_seq_chk.sv
`timescale 1ns/1ps
module pop_seq_chk #(
    parameter int REG_W       = 24,
    parameter int SSP_W       = 16,
    parameter int LONG_BYTES  = 3,
    parameter int SHORT_BYTES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             mem_rd,
    input logic [REG_W-1:0] reg_bc,
    input logic [REG_W-1:0] reg_de,
    input logic [REG_W-1:0] reg_hl,
    input logic [REG_W-1:0] sp_long,
    input logic [SSP_W-1:0] sp_short
);

    localparam logic [REG_W-1:0] LSTEP = REG_W'(LONG_BYTES);
    localparam logic [SSP_W-1:0] SSTEP = SSP_W'(SHORT_BYTES);

    assert_done_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_read_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (busy || start));

    assert_sp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(sp_long) && $stable(sp_short)));

    assert_pair_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(reg_bc) && $stable(reg_de) && $stable(reg_hl)));

    assert_one_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($countones({reg_bc != $past(reg_bc),
                              reg_de != $past(reg_de),
                              reg_hl != $past(reg_hl)}) <= 1));

    // R2 / R3 / R10: exactly one pointer steps, by its own byte count, modulo its width
    assert_sp_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ((sp_long == $past(sp_long) + LSTEP && $stable(sp_short)) ||
                  (sp_short == $past(sp_short) + SSTEP && $stable(sp_long))));

endmodule

bind stack_pop_seq pop_seq_chk #(
    .REG_W       (REG_W),
    .SSP_W       (SSP_W),
    .LONG_BYTES  (LONG_BYTES),
    .SHORT_BYTES (SHORT_BYTES)
) u_pop_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .mem_rd   (mem_rd),
    .reg_bc   (reg_bc),
    .reg_de   (reg_de),
    .reg_hl   (reg_hl),
    .sp_long  (sp_long),
    .sp_short (sp_short)
);

// File: tb/test_stack_pop_seq.sv
`timescale 1ns/1ps
module test_stack_pop_seq;

    localparam logic [23:0] LSP0 = 24'hFFFFFC;
    localparam logic [15:0] SSP0 = 16'hFFFD;
    localparam logic [7:0]  BASE = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        long_mode = 1'b0;
    logic [1:0]  size_ovr = 2'b00;
    logic [1:0]  reg_sel = 2'b00;
    logic [7:0]  short_base = BASE;
    logic        mem_rd;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        busy, done;
    logic [23:0] reg_bc, reg_de, reg_hl, sp_long;
    logic [15:0] sp_short;

    int checks = 0;
    int errors = 0;

    logic [23:0] m_pair [3];
    logic [23:0] m_lsp = LSP0;
    logic [15:0] m_ssp = SSP0;

    logic [23:0] alog [64];
    int          n_log = 0;

    always #4 clk = ~clk;

    stack_pop_seq #(
        .LSP_RST (LSP0),
        .SSP_RST (SSP0)
    ) i_stack_pop_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .long_mode  (long_mode),
        .size_ovr   (size_ovr),
        .reg_sel    (reg_sel),
        .short_base (short_base),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .done       (done),
        .reg_bc     (reg_bc),
        .reg_de     (reg_de),
        .reg_hl     (reg_hl),
        .sp_long    (sp_long),
        .sp_short   (sp_short)
    );

    function automatic logic [7:0] memf(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'hA5;
    endfunction

    // memory model: one-cycle read latency, address logged on every read
    always @(posedge clk) begin
        mem_rdata <= memf(mem_addr);
        if (mem_rd) begin
            alog[n_log % 64] <= mem_addr;
            n_log <= n_log + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk(req, "BC", {8'h0, reg_bc}, {8'h0, m_pair[0]});
        chk(req, "DE", {8'h0, reg_de}, {8'h0, m_pair[1]});
        chk(req, "HL", {8'h0, reg_hl}, {8'h0, m_pair[2]});
        chk(req, "sp_long", {8'h0, sp_long}, {8'h0, m_lsp});
        chk(req, "sp_short", {16'h0, sp_short}, {16'h0, m_ssp});
        chk(req, "busy idle", {31'h0, busy}, 32'h0);
    endtask

    // one pop; optionally a second start while busy that must be ignored (R8)
    task automatic run_pop(input string req, input logic md, input logic [1:0] ov,
                           input logic [1:0] sel, input bit inject);
        logic        lng, pre;
        int          nb, exp_cyc, got_cyc, log0, idx;
        logic [23:0] a, val;
        lng = (ov == 2'b10) ? 1'b1 : (ov == 2'b01) ? 1'b0 : md;
        pre = (ov == 2'b01) || (ov == 2'b10);
        nb  = lng ? 3 : 2;
        exp_cyc = nb + 1 + (pre ? 1 : 0);
        got_cyc = 0;
        @(negedge clk);
        log0 = n_log;
        long_mode = md; size_ovr = ov; reg_sel = sel; start = 1'b1;
        for (int c = 1; c <= 8; c++) begin
            #1;
            if (done && got_cyc == 0) got_cyc = c;
            @(negedge clk);
            if (c == 1) begin
                start = inject;
                if (inject) begin
                    long_mode = ~md; size_ovr = 2'b01; reg_sel = 2'b00;
                end
            end
            if (c == 2) start = 1'b0;
        end
        #1;
        // expected values from the requirements
        idx = (sel == 2'b11) ? 2 : int'(sel);
        val = m_pair[idx];
        chk(req, "done cycle (R5)", got_cyc, exp_cyc);
        chk(req, "read count (R6)", n_log - log0, nb);
        for (int k = 0; k < nb; k++) begin
            a = lng ? m_lsp + 24'(k) : {BASE, m_ssp + 16'(k)};
            chk(req, "read address (R2/R3)", {8'h0, alog[(log0 + k) % 64]}, {8'h0, a});
            val[k*8 +: 8] = memf(a);
        end
        m_pair[idx] = val;
        if (lng) m_lsp = m_lsp + 24'd3;
        else     m_ssp = m_ssp + 16'd2;
        check_state(req);
    endtask

    task automatic t_reset();
        chk("R9", "done", {31'h0, done}, 32'h0);
        chk("R9", "mem_rd", {31'h0, mem_rd}, 32'h0);
        check_state("R9");
    endtask

    task automatic t_long_plain();  run_pop("R2", 1'b1, 2'b00, 2'b00, 1'b0); endtask
    task automatic t_short_plain(); run_pop("R3", 1'b0, 2'b00, 2'b00, 1'b0); endtask
    // short override, pointer crosses 16'hFFFF inside the pop
    task automatic t_short_ovr();   run_pop("R10", 1'b1, 2'b01, 2'b01, 1'b0); endtask
    // long override, pointer crosses 24'hFFFFFF inside the pop
    task automatic t_long_ovr();    run_pop("R4", 1'b0, 2'b10, 2'b10, 1'b0); endtask
    // spare override code and spare select code (R1, R4)
    task automatic t_alt_codes();   run_pop("R1", 1'b0, 2'b11, 2'b11, 1'b0); endtask
    task automatic t_alt_long();    run_pop("R4", 1'b1, 2'b11, 2'b01, 1'b0); endtask
    task automatic t_busy_start();  run_pop("R8", 1'b1, 2'b00, 2'b01, 1'b1); endtask
    task automatic t_only_sel();    run_pop("R7", 1'b0, 2'b00, 2'b10, 1'b1); endtask

    initial begin
        m_pair[0] = '0; m_pair[1] = '0; m_pair[2] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_long_plain();
        t_short_plain();
        t_short_ovr();
        t_long_ovr();
        t_alt_codes();
        t_alt_long();
        t_busy_start();
        t_only_sel();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule